// File: doc/BRIEF.md
# MMIO Register File Responder

This block is a small bank of 64-bit registers that a host reaches through memory-mapped reads and writes. Requests come in on one receive channel. Each request has a read strobe or a write strobe, a byte address, a length code, a transaction tag and, for writes, a data word. The block decodes the byte address into a register index. It handles 4-byte and 8-byte accesses, and it also accepts 64-byte block writes that fill eight registers in one request. It flags any request that is misaligned or has an illegal length.

Writes are posted and get no response. Every read is answered as a split transaction on a separate transmit channel, which is a valid/ready stream. The answer carries the request's tag and length code. Answers wait in an ordered queue deep enough for the full number of reads the host may have outstanding, so the transmit side can apply back-pressure and no answer is lost.

The receive channel has no ready signal and must be accepted on every cycle. The host must not raise both strobes in the same cycle. It must not issue a read while RSP_DEPTH answers are still unreturned; an answer counts as returned in the cycle its transfer completes. On the transmit channel, a response transfers on a rising edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the response on offer stays unchanged.

Top module: `mmio_regfile`

## Requirements
- R1: The length code `rx_len` means 0 = 4 bytes, 1 = 8 bytes, 2 = 64 bytes and 3 = reserved. Register i sits at byte address 8*i for i < NREGS. An aligned 8-byte write loads `rx_wdata[63:0]` into the register, and an aligned 8-byte read returns the whole register.
- R2: In a 4-byte access, address bit 2 selects the register half: 1 is bits 63:32 and 0 is bits 31:0. A 4-byte write loads `rx_wdata[31:0]` into that half only. A 4-byte read returns that half in `tx_data[31:0]` with the upper 32 bits zero.
- R3: An aligned 64-byte write at byte address A loads `rx_wdata[64*k+63:64*k]` into the register at A+8*k, for k = 0..7.
- R4: Every read produces exactly one response. The response carries the read's tag in `tx_tag` and its length code in `tx_len`. Responses leave in the order the reads arrived.
- R5: A read of an address with no register (index >= NREGS) returns zero data. A write to such an address changes no register.
- R6: A request is an error when its address is not a multiple of its length, or when its length code is reserved. A read with length code 2 is also an error. An error sets `err_misalign` from the next cycle, and the flag stays set until reset. An erroneous write changes no register. An erroneous read is answered with zero data.
- R7: Writes never produce a response.
- R8: A request is accepted on every cycle without stalling. A read issued in the cycle right after a write sees the written value.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_tag`, `tx_len` and `tx_data` hold steady. Up to RSP_DEPTH (default 64) responses are buffered with none dropped.
- R10: After reset, all registers read zero, `tx_valid` is 0 and `err_misalign` is 0.
- R11: When the response queue is empty, `tx_valid` rises in the cycle after the read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_rd_valid | input | 1 | Read request strobe |
| rx_wr_valid | input | 1 | Write request strobe |
| rx_addr | input | ADDR_W | Request byte address |
| rx_len | input | 2 | Length code (0 = 4B, 1 = 8B, 2 = 64B, 3 = reserved) |
| rx_tag | input | TAG_W | Transaction tag |
| rx_wdata | input | 512 | Write data, lane k in bits 64k+63:64k |
| tx_valid | output | 1 | Response available |
| tx_ready | input | 1 | Consumer accepts the response |
| tx_tag | output | TAG_W | Tag echoed from the read |
| tx_len | output | 2 | Length code echoed from the read |
| tx_data | output | 64 | Read data |
| err_misalign | output | 1 | Sticky error for misaligned or illegal requests |

## Verification
The assertions check the following on every cycle:
- Each read adds exactly one entry to the response queue, and each write adds none.
- A stalled response holds steady.
- The queue never overflows.
- Registers change only when a legal write is accepted.
- The error flag, once set, stays set.

Only the bench's scenarios can show that the data values are right. This covers half selection, 64-byte lane placement, zero data from undefined or erroneous reads, tag and order matching across a full 64-deep stall, and visibility of a write to the very next read.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  typedef enum logic [1:0] {
    LEN_4B   = 2'd0,
    LEN_8B   = 2'd1,
    LEN_64B  = 2'd2,
    LEN_RSVD = 2'd3
  } mmio_len_e;

  // True when the low address bits are not a multiple of the access length.
  function automatic logic is_misaligned(input logic [5:0] lo, input mmio_len_e len);
    case (len)
      LEN_4B:  return lo[1:0] != 2'b00;
      LEN_8B:  return lo[2:0] != 3'b000;
      LEN_64B: return lo[5:0] != 6'b000000;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        len_raw,
  output logic [ADDR_W-4:0] idx,
  output logic              half,
  output mmio_len_e         len,
  output logic              rd_bad,
  output logic              wr_bad
);
  logic mis;

  always_comb begin
    len    = mmio_len_e'(len_raw);
    idx    = addr[ADDR_W-1:3];
    half   = addr[2];
    mis    = is_misaligned(addr[5:0], len);
    wr_bad = mis;
    rd_bad = mis || (len != LEN_4B && len != LEN_8B);
  end
endmodule

// File: rtl/mmio_regbank.sv
module mmio_regbank
  import mmio_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NREGS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  mmio_len_e         len,
  input  logic [ADDR_W-4:0] idx,
  input  logic              half,
  input  logic [511:0]      wdata,
  input  logic              rd_bad,
  output logic [63:0]       rdata
);
  localparam int IDXW = ADDR_W - 3;

  logic [NREGS*64-1:0] regs_flat;
  logic [63:0]         sel;

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    localparam int GRP  = gi / 8;
    localparam int LANE = gi % 8;
    logic [63:0] r;
    logic        hit1, hit64;

    assign hit1  = (idx == IDXW'(gi));
    assign hit64 = (idx[IDXW-1:3] == (IDXW-3)'(GRP));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r <= '0;
      end else if (wr_en) begin
        case (len)
          LEN_4B: if (hit1) begin
            if (half) r[63:32] <= wdata[31:0];
            else      r[31:0]  <= wdata[31:0];
          end
          LEN_8B:  if (hit1)  r <= wdata[63:0];
          LEN_64B: if (hit64) r <= wdata[LANE*64 +: 64];
          default: ;
        endcase
      end
    end

    assign regs_flat[gi*64 +: 64] = r;
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (idx == IDXW'(i)) sel = regs_flat[i*64 +: 64];
    end
    if (rd_bad)             rdata = '0;
    else if (len == LEN_4B) rdata = {32'b0, half ? sel[63:32] : sel[31:0]};
    else                    rdata = sel;
  end

  // R6
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));
endmodule

// File: rtl/mmio_rsp_fifo.sv
module mmio_rsp_fifo #(
  parameter int W     = 74,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [W-1:0]             din,
  input  logic                     pop,
  output logic [W-1:0]             dout,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign dout    = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/mmio_regfile.sv
module mmio_regfile
  import mmio_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int TAG_W     = 9,
  parameter int NREGS     = 16,
  parameter int RSP_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_rd_valid,
  input  logic              rx_wr_valid,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [1:0]        rx_len,
  input  logic [TAG_W-1:0]  rx_tag,
  input  logic [511:0]      rx_wdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [TAG_W-1:0]  tx_tag,
  output logic [1:0]        tx_len,
  output logic [63:0]       tx_data,
  output logic              err_misalign
);
  localparam int RW = TAG_W + 2 + 64;
  localparam int CW = $clog2(RSP_DEPTH) + 1;

  logic [ADDR_W-4:0] dec_idx;
  logic              dec_half, dec_rd_bad, dec_wr_bad;
  mmio_len_e         dec_len;
  logic [63:0]       rdata;
  logic [RW-1:0]     q_out;
  logic              q_empty, q_full;
  logic [CW-1:0]     q_cnt;

  mmio_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(rx_addr), .len_raw(rx_len), .idx(dec_idx), .half(dec_half),
    .len(dec_len), .rd_bad(dec_rd_bad), .wr_bad(dec_wr_bad)
  );

  mmio_regbank #(.ADDR_W(ADDR_W), .NREGS(NREGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(rx_wr_valid && !dec_wr_bad),
    .len(dec_len), .idx(dec_idx), .half(dec_half), .wdata(rx_wdata),
    .rd_bad(dec_rd_bad), .rdata(rdata)
  );

  mmio_rsp_fifo #(.W(RW), .DEPTH(RSP_DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(rx_rd_valid),
    .din({rx_tag, rx_len, rdata}), .pop(tx_ready), .dout(q_out),
    .empty(q_empty), .full(q_full), .count(q_cnt)
  );

  assign tx_valid = !q_empty;
  assign {tx_tag, tx_len, tx_data} = q_out;

  always_ff @(posedge clk) begin
    if (!rst_n) err_misalign <= 1'b0;
    else if ((rx_rd_valid && dec_rd_bad) || (rx_wr_valid && dec_wr_bad))
      err_misalign <= 1'b1;
  end

  // R8
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_rd_valid && rx_wr_valid));
  // R4
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_valid |=> int'(q_cnt) == int'($past(q_cnt)) + 1 - int'($past(tx_valid && tx_ready)));
  // R7
  wr_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr_valid && !rx_rd_valid) |=> q_cnt <= $past(q_cnt));
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_tag) && $stable(tx_len) && $stable(tx_data));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_misalign |=> err_misalign);
  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_misalign) |-> $past(rx_rd_valid || rx_wr_valid));
endmodule

// File: tb/sim_mmio_regfile.sv
module sim_mmio_regfile;
  localparam int AW = 8, TW = 8, NR = 8, DEPTH = 64;
  localparam int EW = TW + 2 + 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n, rx_rd_valid, rx_wr_valid, tx_ready;
  logic [AW-1:0]  rx_addr;
  logic [1:0]     rx_len;
  logic [TW-1:0]  rx_tag;
  logic [511:0]   rx_wdata;
  logic           tx_valid, err_misalign;
  logic [TW-1:0]  tx_tag;
  logic [1:0]     tx_len;
  logic [63:0]    tx_data;

  mmio_regfile #(.ADDR_W(AW), .TAG_W(TW), .NREGS(NR), .RSP_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_rd_valid(rx_rd_valid), .rx_wr_valid(rx_wr_valid),
    .rx_addr(rx_addr), .rx_len(rx_len), .rx_tag(rx_tag), .rx_wdata(rx_wdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_tag(tx_tag), .tx_len(tx_len),
    .tx_data(tx_data), .err_misalign(err_misalign)
  );

  logic [63:0]   m_reg [NR];
  logic [EW-1:0] exp_q [$];
  string         lbl_q [$];
  string         cur_lbl = "R1";
  logic [TW-1:0] tag_ctr = '0;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  task automatic check(input string rq, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int i, input int s);
    return {32'(i * 32'h01010101 + s * 7), 32'(32'hC0DE0000 ^ (i * 131 + s))};
  endfunction

  function automatic bit is_bad(input logic [AW-1:0] a, input logic [1:0] l, input bit rd);
    bit mis;
    case (l)
      2'd0: mis = a[1:0] != 0;
      2'd1: mis = a[2:0] != 0;
      2'd2: mis = a[5:0] != 0;
      default: mis = 1;
    endcase
    return mis || (rd && l > 2'd1);
  endfunction

  task automatic send(input bit rd, input bit wr, input logic [AW-1:0] a,
                      input logic [1:0] l, input logic [511:0] d);
    int idx;
    logic [63:0] ed;
    idx = int'(a[AW-1:3]);
    if (rd) begin
      ed = '0;
      if (!is_bad(a, l, 1) && idx < NR)
        ed = (l == 2'd0) ? (a[2] ? {32'b0, m_reg[idx][63:32]} : {32'b0, m_reg[idx][31:0]})
                         : m_reg[idx];
      exp_q.push_back({tag_ctr, l, ed});
      lbl_q.push_back(cur_lbl);
    end
    if (wr && !is_bad(a, l, 0)) begin
      if (l == 2'd0 && idx < NR) begin
        if (a[2]) m_reg[idx][63:32] = d[31:0];
        else      m_reg[idx][31:0]  = d[31:0];
      end else if (l == 2'd1 && idx < NR) begin
        m_reg[idx] = d[63:0];
      end else if (l == 2'd2) begin
        for (int k = 0; k < 8; k++)
          if ((idx & ~7) + k < NR) m_reg[(idx & ~7) + k] = d[64*k +: 64];
      end
    end
    rx_rd_valid = rd; rx_wr_valid = wr; rx_addr = a; rx_len = l;
    rx_tag = tag_ctr; rx_wdata = d;
    @(posedge clk); #2;
    rx_rd_valid = 0; rx_wr_valid = 0;
    tag_ctr++;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // Response monitor, sampled between edges.
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R7 unexpected response actual tag=%h expected none", tx_tag);
      end else begin
        check({lbl_q[0], " R4 response"}, 128'({tx_tag, tx_len, tx_data}), 128'(exp_q[0]));
        void'(exp_q.pop_front());
        void'(lbl_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [511:0] blk;
    for (int i = 0; i < NR; i++) m_reg[i] = '0;
    rst_n = 0; tx_ready = 1; rx_rd_valid = 0; rx_wr_valid = 0;
    rx_addr = '0; rx_len = '0; rx_tag = '0; rx_wdata = '0;
    repeat (3) @(posedge clk); #2;
    check("R10 tx_valid", 128'(tx_valid), 128'(0));
    check("R10 err", 128'(err_misalign), 128'(0));
    rst_n = 1;
    @(posedge clk); #2;

    cur_lbl = "R10";
    for (int i = 0; i < NR; i++) send(1, 0, AW'(8 * i), 2'd1, '0);

    cur_lbl = "R1 R8";
    for (int i = 0; i < NR; i++) begin
      send(0, 1, AW'(8 * i), 2'd1, 512'(pat(i, 1)));
      send(1, 0, AW'(8 * i), 2'd1, '0);
    end

    cur_lbl = "R2";
    for (int i = 0; i < NR; i++) begin
      send(0, 1, AW'(8 * i), 2'd0, 512'(pat(i, 2)));
      send(1, 0, AW'(8 * i), 2'd1, '0);
      send(0, 1, AW'(8 * i + 4), 2'd0, 512'(pat(i, 3)));
      send(1, 0, AW'(8 * i), 2'd0, '0);
      send(1, 0, AW'(8 * i + 4), 2'd0, '0);
      send(1, 0, AW'(8 * i), 2'd1, '0);
    end

    cur_lbl = "R3";
    for (int k = 0; k < 8; k++) blk[64*k +: 64] = pat(k, 9);
    send(0, 1, AW'(0), 2'd2, blk);
    for (int i = 0; i < NR; i++) send(1, 0, AW'(8 * i), 2'd1, '0);

    cur_lbl = "R5";
    for (int i = NR; i < 32; i++) begin
      send(1, 0, AW'(8 * i), 2'd1, '0);
      send(1, 0, AW'(8 * i + 4), 2'd0, '0);
    end
    send(0, 1, AW'(8 * 9), 2'd1, 512'(pat(9, 4)));
    send(0, 1, AW'(64), 2'd2, ~blk);
    for (int i = 0; i < NR; i++) send(1, 0, AW'(8 * i), 2'd1, '0);
    send(1, 0, AW'(8 * 9), 2'd1, '0);
    drain();

    cur_lbl = "R11";
    check("R11 idle tx_valid", 128'(tx_valid), 128'(0));
    send(1, 0, AW'(8 * 2), 2'd1, '0);
    check("R11 tx_valid after one cycle", 128'(tx_valid), 128'(1));
    drain();

    cur_lbl = "R9";
    tx_ready = 0;
    for (int j = 0; j < DEPTH; j++)
      send(1, 0, AW'(8 * (j % NR) + ((j % 3 == 0) ? 4 : 0)), (j % 3 == 0) ? 2'd0 : 2'd1, '0);
    repeat (4) @(posedge clk); #2;
    check("R9 stalled tx_valid", 128'(tx_valid), 128'(1));
    check("R9 stalled head", 128'({tx_tag, tx_len, tx_data}), 128'(exp_q[0]));
    check("R9 queue holds all", 128'(exp_q.size()), 128'(DEPTH));
    tx_ready = 1;
    drain();

    cur_lbl = "R7";
    for (int i = 0; i < 20; i++)
      send(0, 1, AW'(8 * (i % NR)), 2'd1, 512'(pat(i, 5)));
    repeat (5) @(posedge clk); #2;
    check("R7 no write response", 128'(tx_valid), 128'(0));

    cur_lbl = "R6";
    check("R6 err clear before error", 128'(err_misalign), 128'(0));
    send(0, 1, AW'(8 * 3 + 4), 2'd1, 512'(pat(3, 6)));
    check("R6 err set", 128'(err_misalign), 128'(1));
    send(1, 0, AW'(8 * 3), 2'd1, '0);
    send(0, 1, AW'(8 * 4 + 2), 2'd0, 512'(pat(4, 6)));
    send(0, 1, AW'(8), 2'd2, ~blk);
    send(0, 1, AW'(8 * 5), 2'd3, 512'(pat(5, 6)));
    for (int i = 0; i < NR; i++) send(1, 0, AW'(8 * i), 2'd1, '0);
    send(1, 0, AW'(8 * 1 + 4), 2'd1, '0);
    send(1, 0, AW'(8 * 2 + 1), 2'd0, '0);
    send(1, 0, AW'(0), 2'd2, '0);
    send(1, 0, AW'(8 * 6), 2'd3, '0);
    send(0, 1, AW'(8 * 6), 2'd1, 512'(pat(6, 8)));
    send(1, 0, AW'(8 * 6), 2'd1, '0);
    drain();
    check("R6 err sticky", 128'(err_misalign), 128'(1));
    check("R4 all responses returned", 128'(exp_q.size()), 128'(0));

    done = 1;
    finish_run();
  end
endmodule